// File: doc/BRIEF.md
# Operand Effective Address Generator

This block computes, for one instruction at a time, the 16-bit address at which an 8-bit CPU finds its operand or continues after a branch. Memory, I/O and control registers all share one 64 KB linear space. The block takes a mode code, up to two bytes that follow the opcode, the address of the opcode, the current 16-bit index pair (H:X) and a branch-taken flag from the condition logic. From these it produces:

- the effective address, with a valid flag;
- the next program counter;
- the instruction length in bytes;
- any immediate operand;
- the post-incremented index value, with a write strobe.

A request is accepted when `req` is high at a rising edge. All results are registered and appear one cycle later. `ea_valid` and `hx_wr` are single-cycle pulses: they drop in the cycle after any edge where `req` is low. All other outputs hold their last values.

The modes covered are inherent, 8- and 16-bit immediate, zero-page direct, extended, relative branch, indexed with no offset, and indexed with post-increment. Opcode decoding, flag logic and bus timing belong to neighbouring blocks.

Top module: `opnd_ea_gen`

## Requirements
- R1: After reset `ea_valid`, `hx_wr`, `ea`, `next_pc`, `imm`, `hx_next` and `len` are all zero.
- R2: Mode codes on `mode` are as follows. 0 is inherent, 1 is 8-bit immediate, 2 is 16-bit immediate, 3 is direct, 4 is extended, 5 is relative, 6 is indexed, and 7 is indexed with post-increment. Results for a request at edge N are visible after edge N+1.
- R3: `len` reports bytes consumed. It is 1 for modes 0, 6 and 7. It is 2 for modes 1, 3 and 5. It is 3 for modes 2 and 4.
- R4: Mode 3 gives `ea` = {0x00, `op_b1`}, so only 0x0000–0x00FF is reachable.
- R5: Mode 4 gives `ea` = {`op_b1`, `op_b2`}, with the first byte as the high half.
- R6: Mode 1 gives `imm` = {0x00, `op_b1`}. Mode 2 gives `imm` = {`op_b1`, `op_b2`}, with the high byte first. In all other modes `imm` is 0.
- R7: In mode 5 with `br_taken`=1, `next_pc` = `pc` + 2 + sign-extended `op_b1`, modulo 2^16.
- R8: In mode 5 with `br_taken`=0, and in every other mode, `next_pc` = `pc` + `len`, modulo 2^16.
- R9: Modes 6 and 7 give `ea` = `hx`.
- R10: Only mode 7 pulses `hx_wr`, with `hx_next` = `hx` + 1 modulo 2^16. In every other mode `hx_wr` is 0 and `hx_next` = `hx`.
- R11: `ea_valid` is 1 only for modes 3, 4, 6 and 7. In modes 0, 1, 2 and 5 `ea_valid` is 0 and `ea` is 0.
- R12: When `req` is low at an edge, `ea_valid` and `hx_wr` are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe |
| mode | input | 3 | Addressing mode code |
| op_b1 | input | BW | Byte at opcode+1 |
| op_b2 | input | BW | Byte at opcode+2 |
| pc | input | AW | Address of the opcode |
| hx | input | AW | Index pair H:X |
| br_taken | input | 1 | Branch condition true |
| ea | output | AW | Effective address |
| ea_valid | output | 1 | Memory access needed |
| next_pc | output | AW | Program counter after this instruction |
| len | output | 2 | Instruction length in bytes |
| imm | output | AW | Immediate operand |
| hx_next | output | AW | Index pair value to write back |
| hx_wr | output | 1 | Index pair write strobe |

## Verification
The bench builds the block with its defaults: a 16-bit address and 8-bit operand bytes. At these widths the 64 KB wrap points can be reached directly. The bench drives a program counter near 0xFFFF to check that branches and sequential advance wrap. It drives H:X at 0xFFFF to check that post-increment rolls over to zero. It uses offsets of 0x80 and 0x7F to cover both extremes of the signed branch range, in both directions.

// File: rtl/opnd_ea_gen.sv
module opnd_ea_gen #(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [2:0]    mode,
  input  logic [BW-1:0] op_b1,
  input  logic [BW-1:0] op_b2,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] hx,
  input  logic          br_taken,
  output logic [AW-1:0] ea,
  output logic          ea_valid,
  output logic [AW-1:0] next_pc,
  output logic [1:0]    len,
  output logic [AW-1:0] imm,
  output logic [AW-1:0] hx_next,
  output logic          hx_wr
);
  localparam int HW = AW - BW;
  localparam logic [2:0] M_INH = 3'd0, M_IM8 = 3'd1, M_IM16 = 3'd2, M_DIR = 3'd3,
                         M_EXT = 3'd4, M_REL = 3'd5, M_IX = 3'd6, M_IXP = 3'd7;

  logic [AW-1:0] ea_c, imm_c, npc_c, hx_c;
  logic [1:0]    len_c;
  logic          ev_c;

  wire [AW-1:0] pair   = AW'({op_b1, op_b2});
  wire [AW-1:0] zpg    = {{HW{1'b0}}, op_b1};
  wire [AW-1:0] offs   = {{HW{op_b1[BW-1]}}, op_b1};
  wire [AW-1:0] rel_pc = pc + AW'(2) + offs;

  always_comb begin
    ea_c  = '0;
    imm_c = '0;
    ev_c  = 1'b0;
    hx_c  = hx;
    case (mode)
      M_IM8:  len_c = 2'd2;
      M_IM16: len_c = 2'd3;
      M_DIR:  len_c = 2'd2;
      M_EXT:  len_c = 2'd3;
      M_REL:  len_c = 2'd2;
      default: len_c = 2'd1;
    endcase
    case (mode)
      M_IM8:  imm_c = zpg;
      M_IM16: imm_c = pair;
      M_DIR:  begin ea_c = zpg;  ev_c = 1'b1; end
      M_EXT:  begin ea_c = pair; ev_c = 1'b1; end
      M_IX:   begin ea_c = hx;   ev_c = 1'b1; end
      M_IXP:  begin ea_c = hx;   ev_c = 1'b1; hx_c = hx + AW'(1); end
      default: ;
    endcase
    npc_c = (mode == M_REL && br_taken) ? rel_pc : pc + AW'(len_c);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea <= '0; ea_valid <= 1'b0; next_pc <= '0; len <= '0;
      imm <= '0; hx_next <= '0; hx_wr <= 1'b0;
    end else begin
      ea_valid <= req & ev_c;
      hx_wr    <= req & (mode == M_IXP);
      if (req) begin
        ea <= ea_c; next_pc <= npc_c; len <= len_c;
        imm <= imm_c; hx_next <= hx_c;
      end
    end
  end

  // R10
  wr_implies_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hx_wr |-> (ea_valid && hx_next == ea + AW'(1)));
  // R4
  direct_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req) && $past(mode) == M_DIR) |-> (ea[AW-1:BW] == '0 && ea_valid));
  // R3
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req) |-> (len != 2'd0));
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (!ea_valid && !hx_wr));
  // R8
  not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && mode == M_REL && !br_taken) |=> next_pc == $past(pc) + AW'(2));
  // R11
  no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req) && ($past(mode) == M_INH || $past(mode) == M_REL)) |-> !ea_valid);
endmodule

// File: tb/opnd_ea_gen_tb.sv
module opnd_ea_gen_tb;
  logic clk = 0, rst_n = 0, req = 0, br_taken = 0;
  logic [2:0] mode = 0;
  logic [7:0] op_b1 = 0, op_b2 = 0;
  logic [15:0] pc = 0, hx = 0;
  logic [15:0] ea, next_pc, imm, hx_next;
  logic ea_valid, hx_wr;
  logic [1:0] len;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  opnd_ea_gen u_dut (.clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .op_b1(op_b1),
    .op_b2(op_b2), .pc(pc), .hx(hx), .br_taken(br_taken), .ea(ea), .ea_valid(ea_valid),
    .next_pc(next_pc), .len(len), .imm(imm), .hx_next(hx_next), .hx_wr(hx_wr));

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(logic [2:0] m, logic [7:0] b1, logic [7:0] b2,
                       logic [15:0] p, logic [15:0] x, logic t);
    @(negedge clk);
    req = 1; mode = m; op_b1 = b1; op_b2 = b2; pc = p; hx = x; br_taken = t;
    @(posedge clk); #1;
    @(negedge clk); req = 0;
  endtask

  task automatic t_reset;
    chk("R1 ea_valid", 16'(ea_valid), 0); chk("R1 hx_wr", 16'(hx_wr), 0);
    chk("R1 ea", ea, 0); chk("R1 next_pc", next_pc, 0); chk("R1 imm", imm, 0);
    chk("R1 hx_next", hx_next, 0); chk("R1 len", 16'(len), 0);
  endtask

  task automatic t_inherent;
    issue(3'd0, 8'hAA, 8'hBB, 16'h1000, 16'h2222, 0);
    chk("R3 inh len", 16'(len), 1); chk("R11 inh valid", 16'(ea_valid), 0);
    chk("R11 inh ea", ea, 0); chk("R8 inh pc", next_pc, 16'h1001);
    chk("R6 inh imm", imm, 0); chk("R10 inh wr", 16'(hx_wr), 0);
    chk("R10 inh hx", hx_next, 16'h2222);
  endtask

  task automatic t_immediate;
    issue(3'd1, 8'h5C, 8'h00, 16'h2000, 16'h0, 0);
    chk("R6 imm8", imm, 16'h005C); chk("R3 imm8 len", 16'(len), 2);
    chk("R8 imm8 pc", next_pc, 16'h2002); chk("R11 imm8 valid", 16'(ea_valid), 0);
    issue(3'd2, 8'h12, 8'h34, 16'h2000, 16'h0, 0);
    chk("R6 imm16", imm, 16'h1234); chk("R3 imm16 len", 16'(len), 3);
    chk("R8 imm16 pc", next_pc, 16'h2003);
  endtask

  task automatic t_direct_ext;
    issue(3'd3, 8'hF7, 8'h99, 16'h3000, 16'h0, 0);
    chk("R4 dir ea", ea, 16'h00F7); chk("R11 dir valid", 16'(ea_valid), 1);
    chk("R2 dir len", 16'(len), 2); chk("R6 dir imm", imm, 0);
    issue(3'd4, 8'hC0, 8'h1E, 16'h3000, 16'h0, 0);
    chk("R5 ext ea", ea, 16'hC01E); chk("R3 ext len", 16'(len), 3);
    chk("R8 ext pc", next_pc, 16'h3003); chk("R11 ext valid", 16'(ea_valid), 1);
  endtask

  task automatic t_branch;
    issue(3'd5, 8'h10, 8'h0, 16'h4000, 16'h0, 1);
    chk("R7 fwd", next_pc, 16'h4012); chk("R11 rel valid", 16'(ea_valid), 0);
    issue(3'd5, 8'h80, 8'h0, 16'h4000, 16'h0, 1);
    chk("R7 back max", next_pc, 16'h3F82);
    issue(3'd5, 8'h7F, 8'h0, 16'hFFF0, 16'h0, 1);
    chk("R7 wrap", next_pc, 16'h0071);
    issue(3'd5, 8'h80, 8'h0, 16'h4000, 16'h0, 0);
    chk("R8 not taken", next_pc, 16'h4002);
    issue(3'd4, 8'h0, 8'h0, 16'hFFFE, 16'h0, 0);
    chk("R8 seq wrap", next_pc, 16'h0001);
  endtask

  task automatic t_indexed;
    issue(3'd6, 8'h0, 8'h0, 16'h5000, 16'h8123, 0);
    chk("R9 ix ea", ea, 16'h8123); chk("R10 ix wr", 16'(hx_wr), 0);
    chk("R10 ix hx", hx_next, 16'h8123); chk("R3 ix len", 16'(len), 1);
    issue(3'd7, 8'h0, 8'h0, 16'h5000, 16'h8123, 0);
    chk("R9 ixp ea", ea, 16'h8123); chk("R10 ixp wr", 16'(hx_wr), 1);
    chk("R10 ixp hx", hx_next, 16'h8124);
    chk("R8 ixp pc", next_pc, 16'h5001);
    issue(3'd7, 8'h0, 8'h0, 16'h5000, 16'hFFFF, 0);
    chk("R10 ixp wrap", hx_next, 16'h0000); chk("R9 ixp ea max", ea, 16'hFFFF);
  endtask

  task automatic t_idle;
    issue(3'd7, 8'h0, 8'h0, 16'h6000, 16'h0100, 0);
    @(posedge clk); #1;
    chk("R12 wr drops", 16'(hx_wr), 0); chk("R12 valid drops", 16'(ea_valid), 0);
    chk("R12 hold ea", ea, 16'h0100);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1;
    t_inherent(); t_immediate(); t_direct_ext(); t_branch(); t_indexed(); t_idle();
    finish_run();
  end

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule